// File: doc/BRIEF.md
# Raster Line Timing and Interrupts

The block counts video scanlines on a strobe that arrives once per line period. A mode input selects either a 525-line field (60 Hz standard) or a 625-line field (50 Hz standard). When the count runs past the last line of the field it returns to zero and signals vertical retrace. Software loads a 32-bit compare word that holds two independent raster positions. Each position raises its own scanline event when the counter lands on it.

After each retrace, the request to present a new frame is held back. It is released when the counter reaches a fixed line (65). It is released earlier if software writes a new display base address while the request is pending. Every release increments a 32-bit frame counter.

All events are single-cycle pulses, registered in the clock cycle that samples the tick or the write. The horizontal timing inside a line and the generation of the line strobe itself belong to the surrounding logic.

Top module: `raster_line_timer`

## Requirements
- R1: After reset the line counter is 0, both compare positions are 0, no frame request is pending, all event outputs are low and `frame_count_o` is 0.
- R2: With `std_sel` = 0, each `line_tick` advances the line by one. The tick that would take the line to 525 sets it to 0 and pulses `retrace_o`. Outputs respond in the cycle after the tick is sampled.
- R3: With `std_sel` = 1 the same wrap happens at 625 lines instead of 525.
- R4: A compare write (`cmp_wr`) loads position 1 from `cmp_wdata[25:16]` and position 2 from `cmp_wdata[9:0]`. All other bits are ignored.
- R5: On each tick, the new line value is compared with both positions. `cmp1_o` and `cmp2_o` pulse independently, and both pulse on the same tick when both positions match. A compare position of 0 matches on the wrap tick.
- R6: A wrap sets the pending flag. A tick that brings the line to 65 while the flag is set pulses `present_o` once and clears the flag. Line 65 with no flag set gives no pulse.
- R7: A `base_wr` while the flag is set pulses `present_o` in the next cycle and clears the flag, so the following line 65 gives no pulse. A `base_wr` with no flag set has no effect.
- R8: `frame_count_o` increases by exactly one with each `present_o` pulse and is otherwise unchanged.
- R9: Every event output is high for one cycle only. `retrace_o`, `cmp1_o` and `cmp2_o` never pulse without a sampled tick.
- R10: If `std_sel` is changed so that the current line is already at or beyond the new field length, the next tick wraps the line to 0 with a retrace pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe per scanline period |
| std_sel | input | 1 | 0 selects 525 lines, 1 selects 625 lines |
| cmp_wr | input | 1 | Write strobe for the compare word |
| cmp_wdata | input | 32 | Compare word, positions at [25:16] and [9:0] |
| base_wr | input | 1 | Strobe for a display base address write |
| retrace_o | output | 1 | Retrace event pulse |
| cmp1_o | output | 1 | Scanline compare 1 pulse |
| cmp2_o | output | 1 | Scanline compare 2 pulse |
| present_o | output | 1 | Frame-present request pulse |
| frame_count_o | output | 32 | Number of frame-present pulses since reset |

## Verification
The hardest states to reach from the ports are the interactions of the pending flag. These are:
- an early release by a base write, followed by a line 65 that must then stay silent;
- a base write or a line 65 before any retrace, when nothing is pending;
- a mode switch that leaves the counter beyond the new field length.

The stimulus walks whole fields in both standards, tick by tick. At chosen lines it inserts base writes, compare writes and a mode switch taken at line 600 of a 625-line field. A bench model computes every expected pulse and the frame count arithmetically from the requirements.

// File: rtl/rlt_pkg.sv
package rlt_pkg;
  localparam int unsigned RLT_POS_W  = 10;
  localparam int unsigned RLT_NPOS   = 2;
  localparam int unsigned RLT_WORD_W = 32;

  typedef logic [RLT_POS_W-1:0] rlt_pos_t;

  function automatic int unsigned rlt_field_ofs(input int unsigned idx, input int unsigned npos);
    return 16 * (npos - 1 - idx);
  endfunction
endpackage

// File: rtl/rlt_line_counter.sv
module rlt_line_counter #(
  parameter int unsigned LINES_A = 525,
  parameter int unsigned LINES_B = 625,
  parameter int unsigned LINE_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              std_sel,
  output logic [LINE_W-1:0] line_next,
  output logic              tick_wrap,
  output logic              retrace_o
);
  logic [LINE_W-1:0] line_q, line_d;
  logic [LINE_W:0]   total, inc;
  logic              wrap_c, retrace_d, retrace_q;

  always_comb begin
    total     = std_sel ? (LINE_W+1)'(LINES_B) : (LINE_W+1)'(LINES_A);
    inc       = {1'b0, line_q} + 1'b1;
    wrap_c    = (inc >= total);
    line_d    = line_q;
    if (line_tick) line_d = wrap_c ? '0 : inc[LINE_W-1:0];
    retrace_d = line_tick & wrap_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      retrace_q <= 1'b0;
    end else begin
      if (line_tick) line_q <= line_d;
      retrace_q <= retrace_d;
    end
  end

  assign line_next = line_d;
  assign tick_wrap = retrace_d;
  assign retrace_o = retrace_q;

  assert_retrace_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_o |-> $past(line_tick));
  assert_retrace_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_o |=> !retrace_o);
  assert_line_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrace_o) |-> (line_q == '0));
endmodule

// File: rtl/rlt_raster_cmp.sv
module rlt_raster_cmp
  import rlt_pkg::*;
#(
  parameter int unsigned LINE_W = RLT_POS_W,
  parameter int unsigned NPOS   = RLT_NPOS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_wr,
  input  logic [RLT_WORD_W-1:0] cmp_wdata,
  input  logic                  line_tick,
  input  logic [LINE_W-1:0]     line_next,
  output logic [NPOS-1:0]       hit_o
);
  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    localparam int unsigned OFS = rlt_field_ofs(i, NPOS);
    logic [LINE_W-1:0] pos_q, pos_d;
    logic              hit_q, hit_d;

    always_comb begin
      pos_d = cmp_wr ? cmp_wdata[OFS +: LINE_W] : pos_q;
      hit_d = line_tick & (line_next == pos_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q <= '0;
        hit_q <= 1'b0;
      end else begin
        if (cmp_wr) pos_q <= pos_d;
        hit_q <= hit_d;
      end
    end

    assign hit_o[i] = hit_q;

    assert_hit_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(line_tick));
    assert_hit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |=> !hit_q);
  end
endmodule

// File: rtl/rlt_present.sv
module rlt_present #(
  parameter int unsigned PRESENT_LINE = 65,
  parameter int unsigned LINE_W       = 10,
  parameter int unsigned FC_W         = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              tick_wrap,
  input  logic [LINE_W-1:0] line_next,
  input  logic              base_wr,
  output logic              present_o,
  output logic [FC_W-1:0]   frame_count_o
);
  logic            pend_q, pend_d;
  logic            fire, release_line;
  logic            present_q;
  logic [FC_W-1:0] fc_q, fc_d;

  always_comb begin
    release_line = line_tick & (line_next == LINE_W'(PRESENT_LINE));
    fire         = pend_q & (release_line | base_wr);
    pend_d       = (pend_q & ~fire) | tick_wrap;
    fc_d         = fc_q + FC_W'(fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      present_q <= 1'b0;
      fc_q      <= '0;
    end else begin
      pend_q    <= pend_d;
      present_q <= fire;
      if (fire) fc_q <= fc_d;
    end
  end

  assign present_o     = present_q;
  assign frame_count_o = fc_q;

  assert_present_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |-> $past(pend_q));
  assert_present_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |=> !present_o);
  assert_frame_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !present_o |-> $stable(frame_count_o));
endmodule

// File: rtl/raster_line_timer.sv
module raster_line_timer
  import rlt_pkg::*;
#(
  parameter int unsigned LINES_A      = 525,
  parameter int unsigned LINES_B      = 625,
  parameter int unsigned PRESENT_LINE = 65,
  parameter int unsigned FC_W         = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_tick,
  input  logic                  std_sel,
  input  logic                  cmp_wr,
  input  logic [RLT_WORD_W-1:0] cmp_wdata,
  input  logic                  base_wr,
  output logic                  retrace_o,
  output logic                  cmp1_o,
  output logic                  cmp2_o,
  output logic                  present_o,
  output logic [FC_W-1:0]       frame_count_o
);
  localparam int unsigned LINE_W = RLT_POS_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [LINE_W-1:0] line_next;
  logic              tick_wrap;
  logic [RLT_NPOS-1:0] hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rlt_line_counter #(.LINES_A(LINES_A), .LINES_B(LINES_B), .LINE_W(LINE_W)) u_count (
    .clk(clk), .rst_n(rst_int_n), .line_tick(line_tick), .std_sel(std_sel),
    .line_next(line_next), .tick_wrap(tick_wrap), .retrace_o(retrace_o)
  );

  rlt_raster_cmp #(.LINE_W(LINE_W), .NPOS(RLT_NPOS)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .line_tick(line_tick), .line_next(line_next), .hit_o(hits)
  );

  rlt_present #(.PRESENT_LINE(PRESENT_LINE), .LINE_W(LINE_W), .FC_W(FC_W)) u_pres (
    .clk(clk), .rst_n(rst_int_n), .line_tick(line_tick), .tick_wrap(tick_wrap),
    .line_next(line_next), .base_wr(base_wr), .present_o(present_o),
    .frame_count_o(frame_count_o)
  );

  assign cmp1_o = hits[0];
  assign cmp2_o = hits[1];

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (frame_count_o == '0 && !present_o && !retrace_o));
endmodule

// File: tb/raster_line_timer_bench.sv
module raster_line_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_tick, std_sel, cmp_wr, base_wr;
  logic [31:0] cmp_wdata;
  logic        retrace_o, cmp1_o, cmp2_o, present_o;
  logic [31:0] frame_count_o;

  int checks = 0;
  int errors = 0;

  int m_line, m_p1, m_p2, m_fc;
  bit m_pend;

  always #5 clk = ~clk;

  raster_line_timer u_raster_line_timer (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .std_sel(std_sel),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .base_wr(base_wr),
    .retrace_o(retrace_o), .cmp1_o(cmp1_o), .cmp2_o(cmp2_o),
    .present_o(present_o), .frame_count_o(frame_count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_events(input string req, input bit r, input bit c1, input bit c2, input bit p);
    chk(req, {28'd0, retrace_o, cmp1_o, cmp2_o, present_o}, {28'd0, r, c1, c2, p});
    chk({req, " R8"}, frame_count_o, m_fc);
  endtask

  task automatic do_tick(input string req);
    int total, inc, nl;
    bit wrap, ep;
    total = std_sel ? 625 : 525;
    inc   = m_line + 1;
    wrap  = (inc >= total);
    nl    = wrap ? 0 : inc;
    ep    = m_pend && (nl == 65);
    m_pend = (m_pend && !ep) || wrap;
    if (ep) m_fc++;
    m_line = nl;
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    chk_events(req, wrap, nl == m_p1, nl == m_p2, ep);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk_events(req, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_base(input string req);
    bit ep;
    ep = m_pend;
    m_pend = 1'b0;
    if (ep) m_fc++;
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
    chk_events(req, 1'b0, 1'b0, 1'b0, ep);
  endtask

  task automatic do_cmp(input logic [31:0] w);
    m_p1 = int'(w[25:16]);
    m_p2 = int'(w[9:0]);
    cmp_wr = 1'b1;
    cmp_wdata = w;
    @(negedge clk);
    cmp_wr = 1'b0;
    cmp_wdata = 32'h0;
    chk_events("R4 write quiet", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_to(input int target, input string req);
    while (m_line != target) do_tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_tick = 1'b0; std_sel = 1'b0;
    cmp_wr = 1'b0; cmp_wdata = 32'h0; base_wr = 1'b0;
    m_line = 0; m_p1 = 0; m_p2 = 0; m_fc = 0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_events("R1 reset state", 1'b0, 1'b0, 1'b0, 1'b0);

    // R1/R2: counting from 0 in 525 mode; R9: quiet without ticks
    for (int i = 0; i < 4; i++) begin
      do_tick("R1 R2 first ticks");
      idle_check("R9 no tick quiet");
    end

    // R7: base write with nothing pending has no effect
    do_base("R7 base write idle");
    // R4: stray bits ignored, positions 5 and 7
    do_cmp(32'hFC05_FC07);
    // R6: line 65 before any retrace gives no present
    run_to(100, "R2 R5 R6 field 0");
    // R5: both positions equal
    do_cmp(32'h00C8_00C8);
    run_to(0, "R2 R5 wrap 525");
    // R6: release at line 65
    run_to(70, "R6 release at line");
    run_to(0, "R2 second wrap");
    // R7: early release then silent line 65
    do_tick("R7 after wrap");
    do_base("R7 early release");
    do_base("R7 second write ignored");
    run_to(80, "R7 line 65 silent");

    // R3: 625 mode, positions 0 and 624
    do_cmp(32'h0000_0270);
    std_sel = 1'b1;
    run_to(0, "R3 R5 wrap 625");
    run_to(66, "R3 R6 release");
    run_to(0, "R3 second wrap");
    run_to(600, "R3 run to 600");
    // R10: switch to 525 while beyond its length
    std_sel = 1'b0;
    do_tick("R10 wrap after switch");
    idle_check("R9 single pulse");
    // R7: base write and line 65 interplay on the same pending frame
    run_to(64, "R10 R6 approach");
    do_base("R7 release at 64");
    do_tick("R6 line 65 silent");
    run_to(0, "R2 final wrap");
    run_to(66, "R6 final release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule